// File: doc/BRIEF.md
# UART Receive Byte Queue

This block buffers received bytes between a UART deserializer and the host. Bytes arrive one per cycle on a write strobe, and the host removes them with a read strobe. The block runs in one of two modes. In queue mode, bytes go into a first-in first-out store whose depth is a parameter (default 16). In single-register mode, each byte overwrites one holding register. A line-break event enters the path as a 0x00 byte and sets a break error flag.

A two-bit control register selects the mode and requests a queue flush. The flush request clears itself once it has taken effect. The host sees the following outputs:
- a status word holding the occupancy count and a full flag;
- a data-ready flag;
- the byte it just read;
- a snapshot of the error status, which is cleared by the read that takes the snapshot;
- one-cycle strobes for the receive and error interrupt sources.

Occupancy is tracked by a three-state machine: `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. Its transitions are:
- **fill**: `OCC_EMPTY`→`OCC_PART` on a push (or straight to `OCC_FULL` when the depth is 1);
- **top-off**: `OCC_PART`→`OCC_FULL` when the last slot is taken;
- **drain**: `OCC_PART`→`OCC_EMPTY` when the last byte is popped;
- **relieve**: `OCC_FULL`→`OCC_PART` on a pop with no push;
- **flush**: any state→`OCC_EMPTY`.

An occupancy counter sits beside the state, so a full queue and an empty queue can be told apart even though their pointers are equal. All outputs are registered. An input strobe sampled at a clock edge is reflected on the outputs just after that same edge.

Top module: `rxq_buffer`

## Requirements
- R1: After reset, `ctrl_q`, `fifo_status`, `data_ready`, `data_q`, `err_rdata`, `irq_rx` and `irq_err` are all zero.
- R2: On a control write, bit0 becomes the queue-mode enable and bit1 becomes the flush request. `ctrl_q[1]` reads 1 for one cycle. The next edge then empties the queue, clears data-ready in queue mode and clears `ctrl_q[1]`.
- R3: `fifo_status[7:0]` holds the queue occupancy and `fifo_status[8]` is the full flag. When the queue is full, bit 8 is 1 and bits [7:0] read as zero.
- R4: In queue mode, a read strobe pops the oldest byte into `data_q`, so bytes come out in arrival order. Data-ready stays 1 while bytes remain and drops to 0 when the pop empties the queue.
- R5: In queue mode, a read strobe while the queue is empty loads `data_q` with 0x00 and pulses `irq_err` for one cycle.
- R6: In queue mode, a byte arriving at a full queue is dropped. It sets overrun (error bit 0), pulses `irq_err` and leaves data-ready at 1. If a read strobe falls in the same cycle, that read frees a slot and the byte is accepted.
- R7: Every accepted byte sets data-ready and pulses `irq_rx` for one cycle.
- R8: The error status bits are:
  - bit 0: overrun;
  - bit 1: parity, taken from `rx_parity_err` with `rx_valid`;
  - bit 2: framing, taken from `rx_frame_err` with `rx_valid`;
  - bit 3: break.

  Bits stay set until read. A read strobe copies the status into `err_rdata` and clears it. A bit set in the same cycle as the read survives the read. Any newly set bit pulses `irq_err`.
- R9: A break event enters the path as byte 0x00, sets the break bit and pulses `irq_err`. An `rx_valid` in the same cycle is ignored.
- R10: With `ctrl_q[0]`=0, a received byte is loaded into the holding register, sets data-ready and pulses `irq_rx`. A read returns the holding register and clears data-ready. Queue contents and `fifo_status` are unchanged.
- R11: In queue mode, in the cycle the flush takes effect, arriving bytes and pops are discarded, a read returns 0x00, and no interrupt strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Control write data: bit0 queue enable, bit1 flush request |
| ctrl_q | output | 2 | Control register contents |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_data | input | DW | Received byte |
| rx_parity_err | input | 1 | Parity error flag for the byte on `rx_data` |
| rx_frame_err | input | 1 | Framing error flag for the byte on `rx_data` |
| rx_break | input | 1 | Line-break event strobe |
| data_rd | input | 1 | Host read strobe for receive data |
| data_q | output | DW | Byte returned by the last read |
| data_ready | output | 1 | Receive data available |
| err_rd | input | 1 | Host read strobe for the error status |
| err_rdata | output | 4 | Error status captured by the last read |
| fifo_status | output | 9 | {full, occupancy count} |
| irq_rx | output | 1 | Receive interrupt source strobe |
| irq_err | output | 1 | Error interrupt source strobe |

## Verification
The hardest case to reach is a queue that is exactly full while another event lands in the same cycle: a byte arriving together with a read, a byte arriving alone, or a flush coinciding with traffic. The stimulus fills the queue with exactly the depth in bytes and then issues each of these combinations in turn. After that, a long random phase runs with a high arrival rate, occasional mode switches and flushes, so the full boundary and the flush cycle are crossed many times under a behavioural queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ERR_W   = 4;
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;
    localparam int STAT_CW = 8;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] cnt;

    generate
        if (DEPTH == (1 << PW)) begin : g_pow2
            assign wr_nxt = wr_ptr + PW'(1);
            assign rd_nxt = rd_ptr + PW'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            if (push && !pop)      cnt <= cnt + CW'(1);
            else if (pop && !push) cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((cnt < CW'(DEPTH)) || pop)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0)); // R5
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat #(
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] set_bits,
    input  logic          rd,
    output logic [EW-1:0] rd_value
);
    logic [EW-1:0] live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live     <= '0;
            rd_value <= '0;
        end else begin
            live <= (rd ? '0 : live) | set_bits;
            if (rd) rd_value <= live;
        end
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (set_bits == '0)) |=> (live == '0)); // R8
    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (($past(live) & ~live) == '0)); // R8
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [1:0]           ctrl_wdata,
    output logic [1:0]           ctrl_q,
    input  logic                 rx_valid,
    input  logic [DW-1:0]        rx_data,
    input  logic                 rx_parity_err,
    input  logic                 rx_frame_err,
    input  logic                 rx_break,
    input  logic                 data_rd,
    output logic [DW-1:0]        data_q,
    output logic                 data_ready,
    input  logic                 err_rd,
    output logic [ERR_W-1:0]     err_rdata,
    output logic [STAT_CW:0]     fifo_status,
    output logic                 irq_rx,
    output logic                 irq_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              fifo_en_q, flush_q;
    logic [CW-1:0]     cnt, cnt_next;
    logic [DW-1:0]     head, hold_q, in_byte;
    occ_t              occ_q, occ_d;
    logic              full, empty;
    logic              in_valid, pop, push, drop, empty_rd;
    logic [ERR_W-1:0]  err_set;

    // control register: flush bit clears itself after one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
            flush_q   <= 1'b0;
        end else begin
            flush_q <= ctrl_wr && ctrl_wdata[1];
            if (ctrl_wr) fifo_en_q <= ctrl_wdata[0];
        end
    end
    assign ctrl_q = {flush_q, fifo_en_q};

    // event decode
    always_comb begin
        in_valid = rx_valid || rx_break;
        in_byte  = rx_break ? '0 : rx_data;
        pop      = fifo_en_q && !flush_q && data_rd && !empty;
        empty_rd = fifo_en_q && !flush_q && data_rd && empty;
        push     = fifo_en_q && !flush_q && in_valid && (!full || pop);
        drop     = fifo_en_q && !flush_q && in_valid && full && !pop;
        err_set          = '0;
        err_set[ERR_OVR] = drop;
        err_set[ERR_PAR] = rx_valid && !rx_break && rx_parity_err;
        err_set[ERR_FRM] = rx_valid && !rx_break && rx_frame_err;
        err_set[ERR_BRK] = rx_break;
    end

    always_comb begin
        cnt_next = cnt;
        if (flush_q)           cnt_next = '0;
        else if (push && !pop) cnt_next = cnt + CW'(1);
        else if (pop && !push) cnt_next = cnt - CW'(1);
    end

    // occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_d;
    end

    // next state: fill, top-off, drain, relieve, flush
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: if (push) occ_d = (DEPTH == 1) ? OCC_FULL : OCC_PART;
            OCC_PART: begin
                if (cnt_next == '0)               occ_d = OCC_EMPTY;
                else if (cnt_next == CW'(DEPTH))  occ_d = OCC_FULL;
            end
            OCC_FULL:  if (pop && !push) occ_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PART;
            default:   occ_d = OCC_EMPTY;
        endcase
        if (flush_q) occ_d = OCC_EMPTY;
    end

    // state outputs
    always_comb begin
        unique case (occ_q)
            OCC_EMPTY: begin full = 1'b0; empty = 1'b1; end
            OCC_PART:  begin full = 1'b0; empty = 1'b0; end
            OCC_FULL:  begin full = 1'b1; empty = 1'b0; end
            default:   begin full = 1'b0; empty = 1'b1; end
        endcase
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_q),
        .push      (push),
        .push_data (in_byte),
        .pop       (pop),
        .head      (head),
        .count     (cnt)
    );

    rxq_errstat #(.EW(ERR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (err_set),
        .rd       (err_rd),
        .rd_value (err_rdata)
    );

    // host-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            hold_q     <= '0;
            data_ready <= 1'b0;
            irq_rx     <= 1'b0;
            irq_err    <= 1'b0;
        end else begin
            if (fifo_en_q) begin
                data_ready <= (cnt_next != '0);
                if (data_rd) data_q <= pop ? head : '0;
            end else begin
                if (in_valid) hold_q <= in_byte;
                data_ready <= in_valid || (data_ready && !data_rd);
                if (data_rd) data_q <= hold_q;
            end
            irq_rx  <= push || (!fifo_en_q && in_valid);
            irq_err <= empty_rd || (|err_set);
        end
    end

    assign fifo_status = {full, full ? {STAT_CW{1'b0}} : STAT_CW'(cnt)};

    AST_STATE_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ_q == OCC_FULL) == (cnt == CW'(DEPTH))) && ((occ_q == OCC_EMPTY) == (cnt == '0))); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> (fifo_status == '0)); // R2
    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && !ctrl_wr) |=> !ctrl_q[1]); // R2
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (irq_rx && data_ready)); // R7
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |=> (irq_err && (data_q == '0))); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (data_ready && fifo_status[STAT_CW] && irq_err)); // R6
    AST_BREAK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> irq_err); // R9
    AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_q && data_rd && !in_valid) |=> !data_ready); // R10
endmodule

// File: tb/tb_rxq_buffer.sv
`timescale 1ns/1ps
module tb_rxq_buffer;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 0;
    logic [1:0] ctrl_wdata = 0;
    logic [1:0] ctrl_q;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_parity_err = 0, rx_frame_err = 0, rx_break = 0;
    logic       data_rd = 0, err_rd = 0;
    logic [7:0] data_q;
    logic       data_ready;
    logic [3:0] err_rdata;
    logic [8:0] fifo_status;
    logic       irq_rx, irq_err;

    always #2 clk = ~clk;

    rxq_buffer #(.DEPTH(DEPTH), .DW(8)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_break(rx_break), .data_rd(data_rd), .data_q(data_q),
        .data_ready(data_ready), .err_rd(err_rd), .err_rdata(err_rdata),
        .fifo_status(fifo_status), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural model
    int   m_q[$];
    bit   m_en, m_pend, m_ready, m_irx, m_ierr;
    int   m_hold, m_dq, m_err, m_erd;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_status();
        if (m_q.size() == DEPTH) return 32'h100;
        return m_q.size();
    endfunction

    task automatic model_update();
        bit inv, flush;
        int ib, set;
        flush = m_pend;
        inv   = rx_valid || rx_break;
        ib    = rx_break ? 0 : int'(rx_data);
        set   = 0;
        if (rx_break) set |= 8;
        if (rx_valid && !rx_break && rx_parity_err) set |= 2;
        if (rx_valid && !rx_break && rx_frame_err)  set |= 4;
        m_irx = 0;
        m_ierr = 0;
        if (m_en) begin
            if (flush) begin
                m_q.delete();
                if (data_rd) m_dq = 0;
            end else begin
                if (data_rd) begin
                    if (m_q.size() > 0) m_dq = m_q.pop_front();
                    else begin m_dq = 0; m_ierr = 1; end
                end
                if (inv) begin
                    if (m_q.size() < DEPTH) begin m_q.push_back(ib); m_irx = 1; end
                    else set |= 1;
                end
            end
            m_ready = (m_q.size() != 0);
        end else begin
            if (data_rd) m_dq = m_hold;
            m_ready = inv || (m_ready && !data_rd);
            if (inv) begin m_hold = ib; m_irx = 1; end
            if (flush) m_q.delete();
        end
        if (err_rd) begin m_erd = m_err; m_err = 0; end
        m_err |= set;
        if (set != 0) m_ierr = 1;
        m_pend = ctrl_wr && ctrl_wdata[1];
        if (ctrl_wr) m_en = ctrl_wdata[0];
    endtask

    task automatic compare_all();
        chk("R2 ctrl_q", int'(ctrl_q), {m_pend, m_en});
        chk("R3 fifo_status", int'(fifo_status), exp_status());
        chk("R4 data_ready", int'(data_ready), int'(m_ready));
        chk("R4 data_q", int'(data_q), m_dq);
        chk("R8 err_rdata", int'(err_rdata), m_erd);
        chk("R7 irq_rx", int'(irq_rx), int'(m_irx));
        chk("R5 irq_err", int'(irq_err), int'(m_ierr));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic cyc(input bit rv, input int rd, input bit par, input bit frm,
                       input bit brk, input bit drd, input bit erd,
                       input bit cw, input int cwd);
        rx_valid = rv; rx_data = 8'(rd); rx_parity_err = par; rx_frame_err = frm;
        rx_break = brk; data_rd = drd; err_rd = erd; ctrl_wr = cw; ctrl_wdata = 2'(cwd);
        step();
        rx_valid = 0; rx_data = 0; rx_parity_err = 0; rx_frame_err = 0;
        rx_break = 0; data_rd = 0; err_rd = 0; ctrl_wr = 0; ctrl_wdata = 0;
    endtask

    task automatic push_b(input int b); cyc(1, b, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic read_b();            cyc(0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
    task automatic read_err();          cyc(0, 0, 0, 0, 0, 0, 1, 0, 0); endtask
    task automatic wr_ctrl(input int v); cyc(0, 0, 0, 0, 0, 0, 0, 1, v); endtask

    initial begin
        #(4ns * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_pend = 0; m_ready = 0; m_irx = 0; m_ierr = 0;
        m_hold = 0; m_dq = 0; m_err = 0; m_erd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctrl_q", int'(ctrl_q), 0);
        chk("R1 fifo_status", int'(fifo_status), 0);
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 data_q", int'(data_q), 0);
        chk("R1 err_rdata", int'(err_rdata), 0);
        chk("R1 irq", int'({irq_rx, irq_err}), 0);

        wr_ctrl(1);
        chk("R2 enable", int'(ctrl_q), 1);

        push_b(8'hA1);
        chk("R7 irq_rx", int'(irq_rx), 1);
        chk("R7 data_ready", int'(data_ready), 1);
        push_b(8'hB2);
        push_b(8'hC3);
        chk("R3 count", int'(fifo_status), 3);
        read_b(); chk("R4 first", int'(data_q), 8'hA1);
        read_b(); chk("R4 second", int'(data_q), 8'hB2);
        chk("R4 ready kept", int'(data_ready), 1);
        read_b(); chk("R4 third", int'(data_q), 8'hC3);
        chk("R4 ready cleared", int'(data_ready), 0);

        read_b();
        chk("R5 empty read data", int'(data_q), 0);
        chk("R5 empty read irq", int'(irq_err), 1);

        for (int i = 0; i < DEPTH; i++) push_b(i * 3 + 1);
        chk("R3 full flag, count zero", int'(fifo_status), 9'h100);
        push_b(8'hEE);
        chk("R6 dropped no irq_rx", int'(irq_rx), 0);
        chk("R6 irq_err", int'(irq_err), 1);
        chk("R6 ready kept", int'(data_ready), 1);
        chk("R6 still full", int'(fifo_status), 9'h100);
        cyc(1, 8'h77, 0, 0, 0, 1, 0, 0, 0);
        chk("R6 read frees slot data", int'(data_q), 1);
        chk("R6 read frees slot irq_rx", int'(irq_rx), 1);
        chk("R6 stays full", int'(fifo_status), 9'h100);
        read_err();
        chk("R8 overrun bit0", int'(err_rdata), 1);
        read_err();
        chk("R8 cleared on read", int'(err_rdata), 0);

        wr_ctrl(3);
        chk("R2 flush bit visible", int'(ctrl_q), 3);
        cyc(1, 8'h44, 0, 0, 0, 1, 0, 0, 0);
        chk("R11 flush read returns zero", int'(data_q), 0);
        chk("R11 no strobes", int'({irq_rx, irq_err}), 0);
        chk("R2 flush self-clears", int'(ctrl_q), 1);
        chk("R2 emptied", int'(fifo_status), 0);
        chk("R2 ready cleared", int'(data_ready), 0);

        cyc(1, 8'h10, 1, 0, 0, 0, 0, 0, 0);
        chk("R8 parity irq_err", int'(irq_err), 1);
        cyc(1, 8'h20, 0, 1, 0, 0, 1, 0, 0);
        chk("R8 parity bit1", int'(err_rdata), 2);
        read_err();
        chk("R8 frame bit2 survives read", int'(err_rdata), 4);

        cyc(1, 8'h55, 0, 0, 1, 0, 0, 0, 0);
        chk("R9 break irq_err", int'(irq_err), 1);
        chk("R9 break pushes", int'(fifo_status), 3);
        read_b(); read_b(); read_b();
        chk("R9 null byte", int'(data_q), 0);
        read_err();
        chk("R9 break bit3", int'(err_rdata), 8);

        push_b(8'h99);
        wr_ctrl(0);
        push_b(8'h5A);
        chk("R10 hold ready", int'(data_ready), 1);
        chk("R10 hold irq_rx", int'(irq_rx), 1);
        chk("R10 queue untouched", int'(fifo_status), 1);
        read_b();
        chk("R10 hold data", int'(data_q), 8'h5A);
        chk("R10 ready cleared", int'(data_ready), 0);
        read_b();
        chk("R10 repeat read no error", int'(irq_err), 0);
        wr_ctrl(1);
        read_b();
        chk("R10 queue byte kept", int'(data_q), 8'h99);

        for (int n = 0; n < 5000; n++) begin
            int r;
            r = $urandom_range(0, 199);
            cyc($urandom_range(0, 9) < 5, $urandom_range(0, 255),
                $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
                $urandom_range(0, 59) == 0, $urandom_range(0, 9) < 4,
                $urandom_range(0, 9) == 0, r < 3,
                (r == 0) ? 3 : ((r == 1) ? 0 : 1));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule